// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block works out which instruction address comes after the one being executed. It takes the address of the current instruction, the 32-bit instruction word and the two register values read for it. From these it forms the following program counter. An ordinary instruction moves the counter forward by four bytes. A direct jump keeps the upper address region of PC+4 and fills in the rest from a 26-bit target field. A register jump goes to the value of the first source register. A conditional branch adds a sign-extended, word-scaled offset to PC+4 when its condition holds.

The call-style jump also gives the return address, PC+8, and a write enable aimed at register 31. The register file writes that value back. The block is purely combinational and holds no state. It is meant to sit beside the register-read stage of a simple core. Delay slots, exceptions and pipelining belong to the core around it.

Top module: `npc_branch_unit`

## Requirements
- R1: Every instruction that is not a control transfer gives next PC = PC+4, with 32-bit wraparound. Control transfers are opcodes 2 to 7 (instruction bits 31:26), opcode 0 with funct (bits 5:0) 0x08, and opcode 1 with bits 20:16 equal to 0 or 1. Opcode 1 with any other value in bits 20:16 counts as an ordinary instruction.
- R2: Opcode 2 gives next PC = {bits 31:28 of PC+4, instruction bits 25:0, 2'b00}. The region is taken from PC+4, not from PC.
- R3: Opcode 0 with funct 0x08 gives next PC equal to the rs operand value.
- R4: Opcode 4 is taken when rs equals rt. Opcode 5 is taken when they differ. A taken branch goes to PC+4 + (offset << 2), where the offset is instruction bits 15:0. A branch that is not taken goes to PC+4.
- R5: Opcode 1 with bits 20:16 = 0 is taken when rs < 0. With bits 20:16 = 1 it is taken when rs >= 0. The target is the same as in R4.
- R6: Opcode 6 is taken when rs <= 0 and opcode 7 when rs > 0. The target is the same as in R4, and rt has no effect.
- R7: Opcode 3 raises the link write enable, sets the link index to 31 and sets the link value to PC+8. It jumps exactly as opcode 2 does.
- R8: The link write enable is low for every instruction other than opcode 3.
- R9: All rs comparisons treat the operand as a signed 32-bit value, so 0x80000000 is negative and 0x7FFFFFFF is positive.
- R10: The 16-bit offset is sign-extended before it is shifted. An offset with bit 15 set moves backwards, with 32-bit wraparound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| next_pc_o | output | 32 | Address of the next instruction |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Register index for the return address (always 31) |
| link_val_o | output | 32 | Return address, PC+8 |

## Verification
The bound checker evaluates a set of properties on every input change:
- an ordinary instruction steps by four;
- a direct jump keeps the region of PC+4 and places the target field;
- a register jump copies rs;
- a branch resolves only to PC+4 or to its offset target;
- an equality branch with equal operands is always taken;
- the link enable follows opcode 3 alone, and when it is raised it carries PC+8 and index 31.

The checker cannot tell whether the right condition was chosen for a branch that may or may not be taken. Signed boundary values, offset wraparound and region crossings at PC+4 are shown only by the bench. Its sweeps cover every opcode, funct and sub-opcode against rs values at and around zero and at both signed extremes.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam logic [5:0] OP_SPECIAL = 6'h00;
   localparam logic [5:0] OP_REGIMM  = 6'h01;
   localparam logic [5:0] OP_JUMP    = 6'h02;
   localparam logic [5:0] OP_CALL    = 6'h03;
   localparam logic [5:0] OP_BR_EQ   = 6'h04;
   localparam logic [5:0] OP_BR_NE   = 6'h05;
   localparam logic [5:0] OP_BR_LEZ  = 6'h06;
   localparam logic [5:0] OP_BR_GTZ  = 6'h07;
   localparam logic [5:0] FN_REG_JMP = 6'h08;
   localparam logic [4:0] SUB_LTZ    = 5'h00;
   localparam logic [4:0] SUB_GEZ    = 5'h01;

   typedef enum logic [1:0] {
      K_SEQ    = 2'd0,
      K_JUMP   = 2'd1,
      K_JREG   = 2'd2,
      K_BRANCH = 2'd3
   } flow_kind_e;

   typedef enum logic [2:0] {
      C_NONE = 3'd0,
      C_EQ   = 3'd1,
      C_NE   = 3'd2,
      C_LTZ  = 3'd3,
      C_GEZ  = 3'd4,
      C_LEZ  = 3'd5,
      C_GTZ  = 3'd6
   } cond_e;

   typedef struct packed {
      flow_kind_e kind;
      cond_e      cond;
      logic       link;
   } flow_dec_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int OP_W  = 6,
   parameter int FN_W  = 6,
   parameter int SUB_W = 5
) (
   input  logic [OP_W-1:0]  op_i,
   input  logic [FN_W-1:0]  funct_i,
   input  logic [SUB_W-1:0] subop_i,
   output flow_dec_t        dec_o
);

   if (OP_W != 6 || FN_W != 6 || SUB_W != 5) begin : g_bad_fields
      $error("npc_decode: field widths must be 6/6/5");
   end

   always_comb begin
      dec_o.kind = K_SEQ;
      dec_o.cond = C_NONE;
      dec_o.link = 1'b0;
      unique case (op_i)
         OP_SPECIAL: begin
            if (funct_i == FN_REG_JMP) dec_o.kind = K_JREG;
         end
         OP_REGIMM: begin
            if (subop_i == SUB_LTZ) begin
               dec_o.kind = K_BRANCH;
               dec_o.cond = C_LTZ;
            end else if (subop_i == SUB_GEZ) begin
               dec_o.kind = K_BRANCH;
               dec_o.cond = C_GEZ;
            end
         end
         OP_JUMP: dec_o.kind = K_JUMP;
         OP_CALL: begin
            dec_o.kind = K_JUMP;
            dec_o.link = 1'b1;
         end
         OP_BR_EQ: begin
            dec_o.kind = K_BRANCH;
            dec_o.cond = C_EQ;
         end
         OP_BR_NE: begin
            dec_o.kind = K_BRANCH;
            dec_o.cond = C_NE;
         end
         OP_BR_LEZ: begin
            dec_o.kind = K_BRANCH;
            dec_o.cond = C_LEZ;
         end
         OP_BR_GTZ: begin
            dec_o.kind = K_BRANCH;
            dec_o.cond = C_GTZ;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int XLEN           = 32,
   parameter bit ZERO_BY_REDUCE = 1'b1
) (
   input  cond_e            cond_i,
   input  logic [XLEN-1:0]  a_i,
   input  logic [XLEN-1:0]  b_i,
   output logic             take_o
);

   logic is_zero;
   logic is_neg;

   assign is_neg = a_i[XLEN-1];

   if (ZERO_BY_REDUCE) begin : g_zero_reduce
      assign is_zero = ~|a_i;
   end else begin : g_zero_compare
      assign is_zero = (a_i == '0);
   end

   always_comb begin
      unique case (cond_i)
         C_EQ:    take_o = (a_i == b_i);
         C_NE:    take_o = (a_i != b_i);
         C_LTZ:   take_o = is_neg;
         C_GEZ:   take_o = ~is_neg;
         C_LEZ:   take_o = is_neg | is_zero;
         C_GTZ:   take_o = ~is_neg & ~is_zero;
         default: take_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN  = 32,
   parameter int OFF_W = 16,
   parameter int TGT_W = 26,
   parameter int STEP  = 4
) (
   input  logic [XLEN-1:0]  pc_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [TGT_W-1:0] tgt_i,
   output logic [XLEN-1:0]  seq_o,
   output logic [XLEN-1:0]  br_o,
   output logic [XLEN-1:0]  jmp_o,
   output logic [XLEN-1:0]  link_o
);

   localparam int HI_W  = XLEN - TGT_W - 2;
   localparam int EXT_W = XLEN - OFF_W - 2;

   if (HI_W < 1 || EXT_W < 0) begin : g_bad_width
      $error("npc_target: XLEN too small for the field widths");
   end

   logic [XLEN-1:0] off_scaled;

   assign seq_o      = pc_i + XLEN'(STEP);
   assign link_o     = pc_i + XLEN'(2 * STEP);
   assign off_scaled = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
   assign br_o       = seq_o + off_scaled;
   assign jmp_o      = {seq_o[XLEN-1 -: HI_W], tgt_i, 2'b00};

endmodule

// File: rtl/npc_branch_unit.sv
module npc_branch_unit
   import npc_pkg::*;
#(
   parameter int XLEN           = 32,
   parameter int OP_W           = 6,
   parameter int FN_W           = 6,
   parameter int REG_IDX_W      = 5,
   parameter int OFF_W          = 16,
   parameter int TGT_W          = 26,
   parameter int LINK_REG       = 31,
   parameter bit ZERO_BY_REDUCE = 1'b1
) (
   input  logic [XLEN-1:0]        pc_i,
   input  logic [OP_W+TGT_W-1:0]  instr_i,
   input  logic [XLEN-1:0]        rs_val_i,
   input  logic [XLEN-1:0]        rt_val_i,
   output logic [XLEN-1:0]        next_pc_o,
   output logic                   link_we_o,
   output logic [REG_IDX_W-1:0]   link_idx_o,
   output logic [XLEN-1:0]        link_val_o
);

   localparam int INSTR_W = OP_W + TGT_W;

   if (INSTR_W != 32 || XLEN != 32) begin : g_bad_word
      $error("npc_branch_unit: instruction and data words must be 32 bits");
   end
   if (OFF_W + 2 * REG_IDX_W != TGT_W) begin : g_bad_layout
      $error("npc_branch_unit: offset and register fields must fill the target field");
   end
   if (LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
      $error("npc_branch_unit: link register index out of range");
   end

   flow_dec_t       dec;
   logic            take;
   logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;

   npc_decode #(
      .OP_W  (OP_W),
      .FN_W  (FN_W),
      .SUB_W (REG_IDX_W)
   ) u_decode (
      .op_i    (instr_i[INSTR_W-1 -: OP_W]),
      .funct_i (instr_i[FN_W-1:0]),
      .subop_i (instr_i[OFF_W +: REG_IDX_W]),
      .dec_o   (dec)
   );

   npc_cond #(
      .XLEN           (XLEN),
      .ZERO_BY_REDUCE (ZERO_BY_REDUCE)
   ) u_cond (
      .cond_i (dec.cond),
      .a_i    (rs_val_i),
      .b_i    (rt_val_i),
      .take_o (take)
   );

   npc_target #(
      .XLEN  (XLEN),
      .OFF_W (OFF_W),
      .TGT_W (TGT_W),
      .STEP  (4)
   ) u_target (
      .pc_i   (pc_i),
      .off_i  (instr_i[OFF_W-1:0]),
      .tgt_i  (instr_i[TGT_W-1:0]),
      .seq_o  (seq_pc),
      .br_o   (br_pc),
      .jmp_o  (jmp_pc),
      .link_o (link_val_o)
   );

   always_comb begin
      unique case (dec.kind)
         K_JUMP:   next_pc_o = jmp_pc;
         K_JREG:   next_pc_o = rs_val_i;
         K_BRANCH: next_pc_o = take ? br_pc : seq_pc;
         default:  next_pc_o = seq_pc;
      endcase
   end

   assign link_we_o  = dec.link;
   assign link_idx_o = REG_IDX_W'(LINK_REG);

endmodule

// File: rtl/npc_branch_unit_chk.sv
module npc_branch_unit_chk #(
   parameter int XLEN = 32
) (
   input logic [XLEN-1:0] pc_i,
   input logic [31:0]     instr_i,
   input logic [XLEN-1:0] rs_val_i,
   input logic [XLEN-1:0] rt_val_i,
   input logic [XLEN-1:0] next_pc_o,
   input logic            link_we_o,
   input logic [4:0]      link_idx_o,
   input logic [XLEN-1:0] link_val_o
);

   logic [5:0]      op;
   logic [4:0]      sub;
   logic            is_jr, is_jump, is_branch, is_ctrl;
   logic [XLEN-1:0] p4, tgt_br;

   always_comb begin
      op        = instr_i[31:26];
      sub       = instr_i[20:16];
      p4        = pc_i + 32'd4;
      tgt_br    = p4 + (32'($signed(instr_i[15:0])) << 2);
      is_jr     = (op == 6'h00) && (instr_i[5:0] == 6'h08);
      is_jump   = (op == 6'h02) || (op == 6'h03);
      is_branch = (op >= 6'h04 && op <= 6'h07) || (op == 6'h01 && sub <= 5'd1);
      is_ctrl   = is_jr || is_jump || is_branch;

      if (!is_ctrl) begin
         p_seq_step_r1: assert (next_pc_o == p4)
            else $error("R1 sequential step violated");
      end
      if (is_jump) begin
         p_region_keep_r2: assert (next_pc_o[31:28] == p4[31:28] &&
                                   next_pc_o[27:2] == instr_i[25:0] &&
                                   next_pc_o[1:0] == 2'b00)
            else $error("R2 jump target malformed");
      end
      if (is_jr) begin
         p_jr_copy_r3: assert (next_pc_o == rs_val_i)
            else $error("R3 register jump target wrong");
      end
      if (is_branch) begin
         p_branch_choice_r4: assert (next_pc_o == p4 || next_pc_o == tgt_br)
            else $error("R4 branch resolved to an illegal address");
      end
      if (op == 6'h04 && rs_val_i == rt_val_i) begin
         p_eq_taken_r4: assert (next_pc_o == tgt_br)
            else $error("R4 equal operands did not branch");
      end
      p_link_only_call_r8: assert (link_we_o == (op == 6'h03))
         else $error("R8 link enable on wrong instruction");
      if (link_we_o) begin
         p_link_value_r7: assert (link_val_o == pc_i + 32'd8 && link_idx_o == 5'd31)
            else $error("R7 link value or index wrong");
      end
   end

endmodule

bind npc_branch_unit npc_branch_unit_chk #(.XLEN(XLEN)) u_chk (
   .pc_i       (pc_i),
   .instr_i    (instr_i),
   .rs_val_i   (rs_val_i),
   .rt_val_i   (rt_val_i),
   .next_pc_o  (next_pc_o),
   .link_we_o  (link_we_o),
   .link_idx_o (link_idx_o),
   .link_val_o (link_val_o)
);

// File: tb/npc_branch_unit_test.sv
module npc_branch_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc, instr, rs_v, rt_v;
   logic [31:0] next_pc, link_val;
   logic        link_we;
   logic [4:0]  link_idx;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   npc_branch_unit uut (
      .pc_i       (pc),
      .instr_i    (instr),
      .rs_val_i   (rs_v),
      .rt_val_i   (rt_v),
      .next_pc_o  (next_pc),
      .link_we_o  (link_we),
      .link_idx_o (link_idx),
      .link_val_o (link_val)
   );

   function automatic string tag_of(input logic [31:0] ins);
      logic [5:0] op;
      op = ins[31:26];
      if (op == 6'h00) return (ins[5:0] == 6'h08) ? "R3" : "R1";
      if (op == 6'h01) return (ins[20:16] <= 5'd1) ? "R5" : "R1";
      if (op == 6'h02) return "R2";
      if (op == 6'h03) return "R7";
      if (op == 6'h04 || op == 6'h05) return "R4";
      if (op == 6'h06 || op == 6'h07) return "R6";
      return "R1";
   endfunction

   function automatic logic [31:0] model_next(input logic [31:0] p, input logic [31:0] ins,
                                              input logic [31:0] a, input logic [31:0] b);
      logic [31:0] p4, bt, jt;
      logic        t;
      p4 = p + 32'd4;
      bt = p4 + 32'($signed(ins[15:0])) * 32'd4;
      jt = {p4[31:28], ins[25:0], 2'b00};
      case (ins[31:26])
         6'h00: return (ins[5:0] == 6'h08) ? a : p4;
         6'h01: begin
            if (ins[20:16] == 5'd0) t = ($signed(a) < 0);
            else if (ins[20:16] == 5'd1) t = ($signed(a) >= 0);
            else return p4;
            return t ? bt : p4;
         end
         6'h02, 6'h03: return jt;
         6'h04: return (a == b) ? bt : p4;
         6'h05: return (a != b) ? bt : p4;
         6'h06: return ($signed(a) <= 0) ? bt : p4;
         6'h07: return ($signed(a) > 0) ? bt : p4;
         default: return p4;
      endcase
   endfunction

   task automatic check32(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] p, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      pc = p; instr = ins; rs_v = a; rt_v = b;
      #1;
   endtask

   task automatic full_check(input string req);
      logic is_call;
      is_call = (instr[31:26] == 6'h03);
      check32(req, "next pc", next_pc, model_next(pc, instr, rs_v, rt_v));
      check32(is_call ? "R7" : "R8", "link enable", {31'd0, link_we}, {31'd0, is_call});
      if (is_call) begin
         check32("R7", "link value", link_val, pc + 32'd8);
         check32("R7", "link index", {27'd0, link_idx}, 32'd31);
      end
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rs_set [7];
      logic [31:0] pc_set [3];
      logic [15:0] off_set[2];
      rs_set = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                 32'h7FFF_FFFF, 32'h1234_5678, 32'hF000_0010};
      pc_set = '{32'h0000_1000, 32'h0FFF_FFFC, 32'hFFFF_FFF8};
      off_set = '{16'h0012, 16'hFFF0};

      pc = '0; instr = '0; rs_v = '0; rt_v = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset-state pattern: all-zero inputs is an ordinary instruction (R1)
      apply(32'h0, 32'h0, 32'h0, 32'h0);
      check32("R1", "idle next pc", next_pc, 32'h4);
      check32("R8", "idle link enable", {31'd0, link_we}, 32'd0);

      // sweep all opcodes against operands, offsets and PCs
      for (int op = 0; op < 64; op++) begin
         for (int pi = 0; pi < 3; pi++) begin
            for (int oi = 0; oi < 2; oi++) begin
               for (int ri = 0; ri < 7; ri++) begin
                  for (int same = 0; same < 2; same++) begin
                     logic [31:0] ins;
                     ins = {6'(op), 5'd3, 5'd0, off_set[oi]};
                     if (op == 2 || op == 3) ins[25:0] = 26'h2A5_5A5C ^ 26'(ri);
                     apply(pc_set[pi], ins, rs_set[ri],
                           same != 0 ? rs_set[ri] : rs_set[ri] ^ 32'h0000_0100);
                     full_check(tag_of(ins));
                  end
               end
            end
         end
      end

      // every funct under opcode 0 (R1, R3)
      for (int fn = 0; fn < 64; fn++) begin
         logic [31:0] ins;
         ins = {6'h00, 5'd4, 5'd5, 5'd6, 5'd0, 6'(fn)};
         apply(32'h0040_0020, ins, 32'hDEAD_BEE0, 32'h0);
         full_check(tag_of(ins));
      end

      // every sub-opcode under opcode 1 (R1, R5)
      for (int sb = 0; sb < 32; sb++) begin
         for (int ri = 0; ri < 7; ri++) begin
            logic [31:0] ins;
            ins = {6'h01, 5'd2, 5'(sb), 16'h0040};
            apply(32'h0000_2000, ins, rs_set[ri], 32'h0);
            full_check(tag_of(ins));
         end
      end

      // signed extremes (R9)
      apply(32'h100, {6'h07, 5'd1, 5'd0, 16'h0004}, 32'h8000_0000, 32'h0);
      check32("R9", "gtz on most negative", next_pc, 32'h104);
      apply(32'h100, {6'h07, 5'd1, 5'd0, 16'h0004}, 32'h7FFF_FFFF, 32'h0);
      check32("R9", "gtz on most positive", next_pc, 32'h114);
      apply(32'h100, {6'h01, 5'd1, 5'd0, 16'h0004}, 32'h8000_0000, 32'h0);
      check32("R9", "ltz on most negative", next_pc, 32'h114);

      // rt has no effect for the sign-test branches (R6)
      apply(32'h200, {6'h06, 5'd1, 5'd9, 16'h0002}, 32'h1, 32'hFFFF_FFFF);
      check32("R6", "lez ignores rt", next_pc, 32'h204);

      // backward offset and wraparound (R10)
      apply(32'h0000_0010, {6'h04, 5'd1, 5'd1, 16'h8000}, 32'h5, 32'h5);
      check32("R10", "most negative offset wraps", next_pc, 32'hFFFE_0014);
      apply(32'h0000_1000, {6'h05, 5'd1, 5'd2, 16'hFFFF}, 32'h5, 32'h6);
      check32("R10", "offset minus one", next_pc, 32'h0000_1000);

      // region taken from PC+4 (R2), call at region edge (R7)
      apply(32'h0FFF_FFFC, {6'h02, 26'h000_0001}, 32'h0, 32'h0);
      check32("R2", "region from PC+4", next_pc, 32'h1000_0004);
      apply(32'hFFFF_FFFC, {6'h03, 26'h3FF_FFFF}, 32'h0, 32'h0);
      check32("R7", "call wrap target", next_pc, 32'h0FFF_FFFC);
      check32("R7", "call wrap link", link_val, 32'h0000_0004);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule